// File: doc/BRIEF.md
# T-Flag Arithmetic and Word Rearrangement Unit

This unit executes one 16-bit instruction per cycle over two 32-bit register operands. It covers add and subtract, including a form that chains a carry or borrow through the single-bit T flag and a form that reports signed overflow on T. It also covers negation with and without borrow, bitwise logic, sign and zero extension, byte and halfword swaps, and extraction of the middle word of a register pair.

The issue stage presents the instruction word, the values of the destination register (Rn) and source register (Rm), and the current T, all qualified by a valid strobe. The 8-bit immediate of the add-immediate form is taken from the low byte of the instruction. One clock later the unit offers a destination write (enable, register index, value) and an optional T write. Unrecognised encodings produce no write.

Top module: `tflag_alu`

## Requirements
- R1: Outputs are registered. An instruction accepted with `valid_i` high produces its writes exactly one clock later. A cycle without valid, and reset, leave both write enables low and the index and data outputs at zero.
- R2: Encoding 0011nnnnmmmm1110 writes Rn+Rm+T to Rn and the carry out of bit 31 to T.
- R3: Encoding 0011nnnnmmmm1010 writes Rn−Rm−T to Rn and the unsigned borrow to T.
- R4: Encoding 0011nnnnmmmm1111 writes Rn+Rm, and encoding 0011nnnnmmmm1011 writes Rn−Rm. Each sets T to 1 exactly when the signed 32-bit result overflows.
- R5: Encoding 0110nnnnmmmm1010 writes 0−Rm−T with the borrow to T. Encoding 0110nnnnmmmm1011 writes 0−Rm and leaves T unwritten.
- R6: Add 0011..1100, subtract 0011..1000, AND 0010..1001, XOR 0010..1010, OR 0010..1011 and NOT of Rm 0110..0111 write Rn and never write T.
- R7: Encodings 0110..1110 and 0110..1111 sign-extend the low byte and the low halfword of Rm. Encodings 0110..1100 and 0110..1101 zero-extend them. T is not written.
- R8: Encoding 0110..1000 exchanges bits 7:0 and 15:8 of Rm and keeps bits 31:16. Encoding 0110..1001 exchanges the two halfwords of Rm. T is not written.
- R9: Encoding 0010..1101 writes {Rm[15:0], Rn[31:16]}, the middle word of the pair Rm:Rn. T is not written.
- R10: Encoding 0111nnnniiiiiiii writes Rn plus the sign-extended 8-bit immediate. T is not written.
- R11: Any other encoding, when valid, asserts neither write enable.
- R12: When the Rn write enable is high, the index output equals instruction bits 11:8. Every T write comes with an Rn write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and operands are valid this cycle |
| instr_i | input | 16 | Instruction word |
| rn_i | input | 32 | Destination register value (first operand) |
| rm_i | input | 32 | Source register value (second operand) |
| t_i | input | 1 | Current T flag |
| rn_we_o | output | 1 | Destination register write enable |
| rn_idx_o | output | 4 | Destination register index |
| rn_data_o | output | 32 | Value to write to the destination register |
| t_we_o | output | 1 | T flag write enable |
| t_o | output | 1 | New T flag value |

## Verification
Every result is due one clock after the cycle in which it was presented, including the T write and the absence of any write. The bench drives each stimulus on a falling edge and computes the expected outputs with a behavioural integer model. It holds that expectation for one cycle and compares it on the next falling edge, so each comparison lands after exactly one rising edge. Idle cycles are mixed into the stream, so the all-zero outputs of R1 are checked in the same comparison.

// File: rtl/tflag_alu_pkg.sv
package tflag_alu_pkg;

    localparam int INSN_W = 16;

    typedef enum logic [4:0] {
        OP_NONE,
        OP_ADD, OP_ADDC, OP_ADDV, OP_ADDI,
        OP_SUB, OP_SUBC, OP_SUBV,
        OP_NEG, OP_NEGC,
        OP_AND, OP_OR, OP_XOR, OP_NOT,
        OP_EXTSB, OP_EXTSW, OP_EXTUB, OP_EXTUW,
        OP_SWPB, OP_SWPW, OP_XTR
    } alu_op_e;

    function automatic logic uses_adder(alu_op_e op);
        case (op)
            OP_ADD, OP_ADDC, OP_ADDV, OP_ADDI,
            OP_SUB, OP_SUBC, OP_SUBV, OP_NEG, OP_NEGC: return 1'b1;
            default:                                   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tflag_alu_dec.sv
module tflag_alu_dec
    import tflag_alu_pkg::*;
(
    input  logic [INSN_W-1:0] instr_i,
    output alu_op_e           op_o
);
    logic [3:0] grp;
    logic [3:0] fn;

    always_comb begin
        grp  = instr_i[INSN_W-1 -: 4];
        fn   = instr_i[3:0];
        op_o = OP_NONE;
        if (grp == 4'h7) begin
            op_o = OP_ADDI;
        end else begin
            case ({grp, fn})
                8'h3C: op_o = OP_ADD;
                8'h3E: op_o = OP_ADDC;
                8'h3F: op_o = OP_ADDV;
                8'h38: op_o = OP_SUB;
                8'h3A: op_o = OP_SUBC;
                8'h3B: op_o = OP_SUBV;
                8'h6B: op_o = OP_NEG;
                8'h6A: op_o = OP_NEGC;
                8'h29: op_o = OP_AND;
                8'h2B: op_o = OP_OR;
                8'h2A: op_o = OP_XOR;
                8'h67: op_o = OP_NOT;
                8'h6E: op_o = OP_EXTSB;
                8'h6F: op_o = OP_EXTSW;
                8'h6C: op_o = OP_EXTUB;
                8'h6D: op_o = OP_EXTUW;
                8'h68: op_o = OP_SWPB;
                8'h69: op_o = OP_SWPW;
                8'h2D: op_o = OP_XTR;
                default: op_o = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/tflag_alu_addsub.sv
module tflag_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cy_o,
    output logic         ov_o
);
    logic [W:0] wide;

    always_comb begin
        if (sub_i)
            wide = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
        else
            wide = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        res_o = wide[W-1:0];
        cy_o  = wide[W];
        if (sub_i)
            ov_o = (a_i[W-1] != b_i[W-1]) && (res_o[W-1] != a_i[W-1]);
        else
            ov_o = (a_i[W-1] == b_i[W-1]) && (res_o[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/tflag_alu_mix.sv
module tflag_alu_mix
    import tflag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] rn_i,
    input  logic [W-1:0] rm_i,
    output logic [W-1:0] y_o
);
    localparam int HW = W / 2;
    localparam int BW = 8;

    always_comb begin
        case (op_i)
            OP_AND:   y_o = rn_i & rm_i;
            OP_OR:    y_o = rn_i | rm_i;
            OP_XOR:   y_o = rn_i ^ rm_i;
            OP_NOT:   y_o = ~rm_i;
            OP_EXTSB: y_o = {{(W-BW){rm_i[BW-1]}}, rm_i[BW-1:0]};
            OP_EXTSW: y_o = {{(W-HW){rm_i[HW-1]}}, rm_i[HW-1:0]};
            OP_EXTUB: y_o = {{(W-BW){1'b0}}, rm_i[BW-1:0]};
            OP_EXTUW: y_o = {{(W-HW){1'b0}}, rm_i[HW-1:0]};
            OP_SWPB:  y_o = {rm_i[W-1:HW], rm_i[BW-1:0], rm_i[HW-1:BW]};
            OP_SWPW:  y_o = {rm_i[HW-1:0], rm_i[W-1:HW]};
            OP_XTR:   y_o = {rm_i[HW-1:0], rn_i[W-1:HW]};
            default:  y_o = '0;
        endcase
    end
endmodule

// File: rtl/tflag_alu.sv
module tflag_alu
    import tflag_alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 8,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [15:0]       instr_i,
    input  logic [W-1:0]      rn_i,
    input  logic [W-1:0]      rm_i,
    input  logic              t_i,
    output logic              rn_we_o,
    output logic [IDX_W-1:0]  rn_idx_o,
    output logic [W-1:0]      rn_data_o,
    output logic              t_we_o,
    output logic              t_o
);
    localparam int IDX_LSB = INSN_W - 4 - IDX_W;

    typedef struct packed {
        logic             rn_we;
        logic [IDX_W-1:0] idx;
        logic [W-1:0]     data;
        logic             t_we;
        logic             t;
    } out_s;

    alu_op_e      op_d;
    logic [W-1:0] a_d, b_d, sum_d, mix_d;
    logic         sub_d, cin_d, cy_d, ov_d;
    out_s         nxt_d, out_q;

    tflag_alu_dec u_dec (
        .instr_i (instr_i),
        .op_o    (op_d)
    );

    always_comb begin
        a_d   = rn_i;
        b_d   = rm_i;
        sub_d = 1'b0;
        cin_d = 1'b0;
        case (op_d)
            OP_ADDC: cin_d = t_i;
            OP_ADDI: b_d   = {{(W-IMM_W){instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};
            OP_SUB, OP_SUBV: sub_d = 1'b1;
            OP_SUBC: begin sub_d = 1'b1; cin_d = t_i; end
            OP_NEG:  begin a_d = '0; sub_d = 1'b1; end
            OP_NEGC: begin a_d = '0; sub_d = 1'b1; cin_d = t_i; end
            default: ;
        endcase
    end

    tflag_alu_addsub #(.W(W)) u_addsub (
        .a_i   (a_d),
        .b_i   (b_d),
        .sub_i (sub_d),
        .cin_i (cin_d),
        .res_o (sum_d),
        .cy_o  (cy_d),
        .ov_o  (ov_d)
    );

    tflag_alu_mix #(.W(W)) u_mix (
        .op_i (op_d),
        .rn_i (rn_i),
        .rm_i (rm_i),
        .y_o  (mix_d)
    );

    always_comb begin
        nxt_d = '0;
        if (valid_i && op_d != OP_NONE) begin
            nxt_d.rn_we = 1'b1;
            nxt_d.idx   = instr_i[IDX_LSB +: IDX_W];
            nxt_d.data  = uses_adder(op_d) ? sum_d : mix_d;
            case (op_d)
                OP_ADDC, OP_SUBC, OP_NEGC: begin
                    nxt_d.t_we = 1'b1;
                    nxt_d.t    = cy_d;
                end
                OP_ADDV, OP_SUBV: begin
                    nxt_d.t_we = 1'b1;
                    nxt_d.t    = ov_d;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= nxt_d;
    end

    assign rn_we_o   = out_q.rn_we;
    assign rn_idx_o  = out_q.idx;
    assign rn_data_o = out_q.data;
    assign t_we_o    = out_q.t_we;
    assign t_o       = out_q.t;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid_i) |-> (!rn_we_o && !t_we_o && rn_data_o == '0 && rn_idx_o == '0));

    // R11
    unknown_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_d == OP_NONE) |=> (!rn_we_o && !t_we_o));

    // R5
    neg_keeps_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_d == OP_NEG) |=> (rn_we_o && !t_we_o));

    // R2
    addc_writes_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_d == OP_ADDC) |=> (rn_we_o && t_we_o));

    // R12
    t_with_rn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_we_o |-> rn_we_o);

    // R6
    plain_add_no_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_d == OP_ADD || op_d == OP_SUB)) |=> !t_we_o);
endmodule

// File: tb/tflag_alu_test.sv
module tflag_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic [31:0] rn_i = '0, rm_i = '0;
    logic        t_i = 1'b0;
    logic        rn_we_o, t_we_o, t_o;
    logic [3:0]  rn_idx_o;
    logic [31:0] rn_data_o;

    int tests = 0;
    int fails = 0;

    logic        e_we, e_twe, e_t;
    logic [3:0]  e_idx;
    logic [31:0] e_data;
    string       e_tag;

    always #4 clk = ~clk;

    tflag_alu uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .rn_i(rn_i), .rm_i(rm_i), .t_i(t_i),
        .rn_we_o(rn_we_o), .rn_idx_o(rn_idx_o), .rn_data_o(rn_data_o),
        .t_we_o(t_we_o), .t_o(t_o)
    );

    function automatic bit s_ovf(longint v);
        return (v > 64'sd2147483647) || (v < -64'sd2147483648);
    endfunction

    task automatic model(input logic v, input logic [15:0] ins, input logic [31:0] rn,
                         input logic [31:0] rm, input logic t);
        longint unsigned u;
        longint s;
        e_we = 0; e_twe = 0; e_t = 0; e_idx = '0; e_data = '0; e_tag = "R1";
        if (!v) return;
        e_we = 1; e_idx = ins[11:8];
        if (ins[15:12] == 4'h7) begin
            e_data = rn + {{24{ins[7]}}, ins[7:0]}; e_tag = "R10";
            return;
        end
        case ({ins[15:12], ins[3:0]})
            8'h3C: begin e_data = rn + rm; e_tag = "R6"; end
            8'h38: begin e_data = rn - rm; e_tag = "R6"; end
            8'h29: begin e_data = rn & rm; e_tag = "R6"; end
            8'h2A: begin e_data = rn ^ rm; e_tag = "R6"; end
            8'h2B: begin e_data = rn | rm; e_tag = "R6"; end
            8'h67: begin e_data = ~rm;     e_tag = "R6"; end
            8'h3E: begin
                u = 64'(rn) + 64'(rm) + 64'(t);
                e_data = u[31:0]; e_twe = 1; e_t = u[32]; e_tag = "R2";
            end
            8'h3A: begin
                e_data = rn - rm - 32'(t); e_twe = 1;
                e_t = (64'(rn) < 64'(rm) + 64'(t)); e_tag = "R3";
            end
            8'h3F: begin
                s = longint'($signed(rn)) + longint'($signed(rm));
                e_data = rn + rm; e_twe = 1; e_t = s_ovf(s); e_tag = "R4";
            end
            8'h3B: begin
                s = longint'($signed(rn)) - longint'($signed(rm));
                e_data = rn - rm; e_twe = 1; e_t = s_ovf(s); e_tag = "R4";
            end
            8'h6A: begin
                e_data = 32'd0 - rm - 32'(t); e_twe = 1;
                e_t = (64'(rm) + 64'(t)) != 0; e_tag = "R5";
            end
            8'h6B: begin e_data = 32'd0 - rm; e_tag = "R5"; end
            8'h6E: begin e_data = 32'($signed(rm[7:0]));  e_tag = "R7"; end
            8'h6F: begin e_data = 32'($signed(rm[15:0])); e_tag = "R7"; end
            8'h6C: begin e_data = rm & 32'hFF;   e_tag = "R7"; end
            8'h6D: begin e_data = rm & 32'hFFFF; e_tag = "R7"; end
            8'h68: begin e_data = {rm[31:16], rm[7:0], rm[15:8]}; e_tag = "R8"; end
            8'h69: begin e_data = {rm[15:0], rm[31:16]};          e_tag = "R8"; end
            8'h2D: begin u = {rm, rn} >> 16; e_data = u[31:0];     e_tag = "R9"; end
            default: begin e_we = 0; e_idx = '0; e_tag = "R11"; end
        endcase
    endtask

    task automatic compare();
        tests++;
        if (rn_we_o !== e_we || rn_idx_o !== e_idx || rn_data_o !== e_data ||
            t_we_o !== e_twe || t_o !== e_t) begin
            fails++;
            $display("FAIL %s (R12 idx) actual we=%0b idx=%0d data=%h twe=%0b t=%0b expected we=%0b idx=%0d data=%h twe=%0b t=%0b",
                     e_tag, rn_we_o, rn_idx_o, rn_data_o, t_we_o, t_o,
                     e_we, e_idx, e_data, e_twe, e_t);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] ins, input logic [31:0] rn,
                        input logic [31:0] rm, input logic t);
        @(negedge clk);
        compare();
        valid_i = v; instr_i = ins; rn_i = rn; rm_i = rm; t_i = t;
        model(v, ins, rn, rm, t);
    endtask

    logic [7:0] keys [20] = '{8'h3C, 8'h3E, 8'h3F, 8'h38, 8'h3A, 8'h3B, 8'h6A, 8'h6B,
                              8'h29, 8'h2A, 8'h2B, 8'h67, 8'h6E, 8'h6F, 8'h6C, 8'h6D,
                              8'h68, 8'h69, 8'h2D, 8'h70};

    initial begin
        // R1: outputs in reset
        valid_i = 1'b1; instr_i = 16'h3E5E; rn_i = '1; rm_i = '1; t_i = 1'b1;
        model(1'b0, '0, '0, '0, 1'b0);
        repeat (3) begin
            @(negedge clk);
            compare();
        end
        valid_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // R2 carry out and no carry
        step(1, 16'h3A2E, 32'hFFFF_FFFF, 32'h0, 1'b1);
        step(1, 16'h312E, 32'h1234_0000, 32'h0000_5678, 1'b1);
        // R3 borrow through T
        step(1, 16'h345A, 32'h0, 32'h0, 1'b1);
        step(1, 16'h345A, 32'h10, 32'h0F, 1'b1);
        // R4 signed overflow both ways
        step(1, 16'h301F, 32'h7FFF_FFFF, 32'h1, 1'b0);
        step(1, 16'h301F, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        step(1, 16'h301B, 32'h8000_0000, 32'h1, 1'b0);
        step(1, 16'h301B, 32'h5, 32'h3, 1'b1);
        // R5 negate with and without borrow
        step(1, 16'h6F0A, 32'h0, 32'h0, 1'b0);
        step(1, 16'h6F0A, 32'h0, 32'h0, 1'b1);
        step(1, 16'h6F0A, 32'h0, 32'hFFFF_FFFF, 1'b1);
        step(1, 16'h6F0B, 32'h0, 32'h1, 1'b1);
        // R1 idle cycle between
        step(0, 16'h3E3E, 32'h1, 32'h1, 1'b1);
        // R7, R8, R9, R10
        step(1, 16'h620E, 32'h0, 32'h1234_5680, 1'b0);
        step(1, 16'h620F, 32'h0, 32'h0000_8001, 1'b0);
        step(1, 16'h620C, 32'h0, 32'hFFFF_FF80, 1'b0);
        step(1, 16'h6208, 32'h0, 32'hAABB_CCDD, 1'b0);
        step(1, 16'h6209, 32'h0, 32'hAABB_CCDD, 1'b0);
        step(1, 16'h2B3D, 32'h1122_3344, 32'h5566_7788, 1'b0);
        step(1, 16'h79FF, 32'h0, 32'h0, 1'b1);
        step(1, 16'h7C80, 32'h0000_0100, 32'h0, 1'b0);
        // R11 unknown encodings
        step(1, 16'h3001, 32'h1, 32'h2, 1'b1);
        step(1, 16'h0000, 32'h1, 32'h2, 1'b1);
        step(1, 16'hF123, 32'h1, 32'h2, 1'b1);
        // mixed stream, every cycle compared
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ins;
            logic [7:0]  k;
            k = keys[$urandom_range(0, 19)];
            ins = {k[7:4], 4'($urandom), 4'($urandom), k[3:0]};
            if (k[7:4] == 4'h7) ins[7:0] = 8'($urandom);
            if ($urandom_range(0, 7) == 0) ins = 16'($urandom);
            step($urandom_range(0, 5) != 0, ins,
                 ($urandom_range(0, 3) == 0) ? 32'h7FFF_FFFF + 32'($urandom_range(0, 2)) : $urandom,
                 ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF - 32'($urandom_range(0, 1)) : $urandom,
                 1'($urandom));
        end
        step(0, '0, '0, '0, 1'b0);
        @(negedge clk);
        compare();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule